// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block owns the program counter of a 32-bit RISC core whose architecture has a branch delay slot. It decides, every cycle, which address is fetched next: the sequential address, the address after the delay slot, a register target, an absolute jump target, or a PC-relative branch target. It raises a taken flag and a nullify flag, and it produces the register index and value for linking. The taken flag follows the result of a condition test on the register operands. The nullify flag tells the pipeline to drop the delay-slot instruction when a likely branch falls through.

The decoder supplies the PC-source code, the condition code and a link request. The register file supplies two operand values. An interrupt request overrides whatever the decoder asked for. The unit then jumps unconditionally to the address presented on the first operand port, which the decoder points at the interrupt-vector special register. It also reports that the current PC must be saved to the exception-return special register. The PC register resets synchronously to a fixed vector, and a stall input freezes it.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-low reset loads `pc` with the parameter `RESET_VEC` (default 0xBFC0_0000). Reset wins over `stall`.
- R2: At each rising edge out of reset, `pc` takes the value `next_pc` showed before the edge when `stall` is 0, and keeps its value when `stall` is 1.
- R3: `pc_sel` code 0 gives `next_pc` = `pc`+4 and code 1 gives `pc`+8. Codes 6 and 7 behave like code 0. All of these leave `taken` and `nullify` at 0.
- R4: `pc_sel` code 3 (absolute jump) gives `next_pc` = {`pc`[31:28], `jfield`, 2'b00} with `taken` = 1.
- R5: `pc_sel` code 2 (register jump) gives `next_pc` = `rs_val` with `taken` = 1, and `cond_sel` has no effect on it.
- R6: `pc_sel` code 4 (normal branch) and code 5 (likely branch) with a true condition give `next_pc` = `pc` + (sign-extended `imm` × 4) and `taken` = 1.
- R7: `cond_sel` codes: 0 equal (`rs_val`==`rt_val`), 1 not equal, 2 `rs_val`<0, 3 `rs_val`<=0, 4 `rs_val`>=0, 5 `rs_val`>0, 6 always, 7 never. The zero tests read `rs_val` as two's complement.
- R8: A normal branch with a false condition gives `next_pc` = `pc`+4, `taken` = 0 and `nullify` = 0.
- R9: A likely branch with a false condition gives `next_pc` = `pc`+4, `taken` = 0 and `nullify` = 1. `nullify` is 0 in every other case.
- R10: With `link_en` = 1 and `pc_sel` code 2, 3, 4 or 5, `link_we` = 1, `link_idx` = 31 and `link_val` = `pc`+8. This holds whether or not the branch is taken. With `pc_sel` code 0 or 1, `link_we` = 0.
- R11: `irq` = 1 overrides all decode inputs. It gives `next_pc` = `rs_val`, `taken` = 1, `nullify` = 0, `link_we` = 1, `link_idx` = 46 and `link_val` = `pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Holds the PC when high |
| pc_sel | input | 3 | PC-source code (see R3–R6) |
| cond_sel | input | 3 | Branch condition code (see R7) |
| link_en | input | 1 | Request to write the return address |
| irq | input | 1 | Interrupt override |
| rs_val | input | 32 | First source operand / register target / interrupt vector |
| rt_val | input | 32 | Second source operand |
| imm | input | 16 | Branch offset in words |
| jfield | input | 26 | Absolute jump word index |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address the PC takes at the next unstalled edge |
| taken | output | 1 | Control transfer chosen |
| nullify | output | 1 | Discard the delay-slot instruction |
| link_we | output | 1 | Write the link value this cycle |
| link_idx | output | 6 | Register index for the link value |
| link_val | output | 32 | Return address to store |

## Verification
The bench drives the zero-compare conditions at their edges: zero itself, the most negative value and one. A design that compared without the sign would take a less-than-zero branch on 0x8000_0000 the wrong way, and one that mixed up the strict and non-strict forms would differ exactly at zero. Negative offsets (0xFFFF, 0x8000) catch a missing sign extension, which would send the branch forward by nearly 256 KiB. An absolute jump from a PC with non-zero upper bits catches a target that drops those bits. A likely branch that falls through must raise the discard flag while a normal one must not, so swapping the two shows up at once. An interrupt arriving together with a failing likely branch and a link request must still transfer, save the current PC to index 46 and keep the delay slot alive.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared encodings for the next-PC unit: the PC-source codes and the
// branch-condition codes. Code values are fixed because the decoder
// drives them as raw 3-bit fields.
package npc_pkg;

    typedef enum logic [2:0] {
        PCS_SEQ4 = 3'd0,
        PCS_SEQ8 = 3'd1,
        PCS_REG  = 3'd2,
        PCS_ABS  = 3'd3,
        PCS_BR   = 3'd4,
        PCS_BRL  = 3'd5
    } pc_src_e;

    typedef enum logic [2:0] {
        CND_EQ  = 3'd0,
        CND_NE  = 3'd1,
        CND_LTZ = 3'd2,
        CND_LEZ = 3'd3,
        CND_GEZ = 3'd4,
        CND_GTZ = 3'd5,
        CND_ALW = 3'd6,
        CND_NEV = 3'd7
    } cond_e;

endpackage

// File: rtl/npc_cond.sv
// Module npc_cond
// Evaluates the branch condition selected by cond_sel on two operand
// values. Assumes two's complement operands; zero tests use opd_a only.
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cond_sel,
    input  logic [XLEN-1:0] opd_a,
    input  logic [XLEN-1:0] opd_b,
    output logic            hit
);

    logic a_neg;
    logic a_zero;
    logic a_eq_b;

    // Primitive facts about the operands shared by all conditions.
    always_comb begin
        a_neg  = opd_a[XLEN-1];
        a_zero = (opd_a == '0);
        a_eq_b = (opd_a == opd_b);
    end

    // Pick the condition requested by the decoder.
    always_comb begin
        unique case (cond_e'(cond_sel))
            CND_EQ:  hit = a_eq_b;
            CND_NE:  hit = !a_eq_b;
            CND_LTZ: hit = a_neg;
            CND_LEZ: hit = a_neg || a_zero;
            CND_GEZ: hit = !a_neg;
            CND_GTZ: hit = !a_neg && !a_zero;
            CND_ALW: hit = 1'b1;
            CND_NEV: hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module npc_target
// Forms every candidate address from the current PC: the two sequential
// addresses, the PC-relative branch target and the absolute jump target.
// Assumes word-aligned instructions (two zero low bits on offsets).
module npc_target #(
    parameter int XLEN = 32,
    parameter int IMM_W = 16,
    parameter int JF_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    output logic [XLEN-1:0]  seq4,
    output logic [XLEN-1:0]  seq8,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  abs_tgt
);

    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam int HI_W  = XLEN - JF_W - 2;

    logic [XLEN-1:0] br_off;

    // Sequential successors: next instruction and the one after the slot.
    always_comb begin
        seq4 = pc + XLEN'(4);
        seq8 = pc + XLEN'(8);
    end

    // Branch offset: sign-extended word count scaled to bytes.
    always_comb begin
        br_off = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt = pc + br_off;
    end

    // Absolute target keeps the PC's top region bits.
    always_comb begin
        abs_tgt = {pc[XLEN-1 -: HI_W], jfield, 2'b00};
    end

endmodule

// File: rtl/npc_link.sv
// Module npc_link
// Produces the register write for linking: the return address after the
// delay slot for linking transfers, or the interrupted PC for an
// interrupt. Assumes the interrupt takes priority over any decode request.
module npc_link
    import npc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IDX_W = 6,
    parameter int RA_IDX = 31,
    parameter int EPC_IDX = 46
) (
    input  logic [2:0]       pc_sel,
    input  logic             link_en,
    input  logic             irq,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  seq8,
    output logic             link_we,
    output logic [IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]  link_val
);

    logic xfer_kind;

    // Only transfer-type sources may link.
    always_comb begin
        unique case (pc_src_e'(pc_sel))
            PCS_REG, PCS_ABS, PCS_BR, PCS_BRL: xfer_kind = 1'b1;
            default:                           xfer_kind = 1'b0;
        endcase
    end

    // Choose the destination and value, interrupt first.
    always_comb begin
        if (irq) begin
            link_we  = 1'b1;
            link_idx = IDX_W'(EPC_IDX);
            link_val = pc;
        end else begin
            link_we  = link_en && xfer_kind;
            link_idx = IDX_W'(RA_IDX);
            link_val = seq8;
        end
    end

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit
// Holds the program counter and resolves the next fetch address from the
// decoder's PC-source and condition codes, with an interrupt override.
// Assumes the decoder presents the interrupt-vector register on rs_val
// while irq is high, and that the delay-slot instruction is already in
// flight when a transfer is resolved.
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMM_W = 16,
    parameter int JF_W = 26,
    parameter int IDX_W = 6,
    parameter int RA_IDX = 31,
    parameter int EPC_IDX = 46,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [2:0]       pc_sel,
    input  logic [2:0]       cond_sel,
    input  logic             link_en,
    input  logic             irq,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  next_pc,
    output logic             taken,
    output logic             nullify,
    output logic             link_we,
    output logic [IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]  link_val
);

    localparam int HI_W = XLEN - JF_W - 2;

    logic [XLEN-1:0] seq4;
    logic [XLEN-1:0] seq8;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] abs_tgt;
    logic            cond_hit;

    npc_cond #(
        .XLEN(XLEN)
    ) u_cond (
        .cond_sel(cond_sel),
        .opd_a   (rs_val),
        .opd_b   (rt_val),
        .hit     (cond_hit)
    );

    npc_target #(
        .XLEN (XLEN),
        .IMM_W(IMM_W),
        .JF_W (JF_W)
    ) u_target (
        .pc     (pc),
        .imm    (imm),
        .jfield (jfield),
        .seq4   (seq4),
        .seq8   (seq8),
        .br_tgt (br_tgt),
        .abs_tgt(abs_tgt)
    );

    npc_link #(
        .XLEN   (XLEN),
        .IDX_W  (IDX_W),
        .RA_IDX (RA_IDX),
        .EPC_IDX(EPC_IDX)
    ) u_link (
        .pc_sel  (pc_sel),
        .link_en (link_en),
        .irq     (irq),
        .pc      (pc),
        .seq8    (seq8),
        .link_we (link_we),
        .link_idx(link_idx),
        .link_val(link_val)
    );

    // Resolve the next address, the taken flag and the slot discard.
    always_comb begin
        next_pc = seq4;
        taken   = 1'b0;
        nullify = 1'b0;
        if (irq) begin
            next_pc = rs_val;
            taken   = 1'b1;
        end else begin
            unique case (pc_src_e'(pc_sel))
                PCS_SEQ8: next_pc = seq8;
                PCS_REG: begin
                    next_pc = rs_val;
                    taken   = 1'b1;
                end
                PCS_ABS: begin
                    next_pc = abs_tgt;
                    taken   = 1'b1;
                end
                PCS_BR: begin
                    taken   = cond_hit;
                    next_pc = cond_hit ? br_tgt : seq4;
                end
                PCS_BRL: begin
                    taken   = cond_hit;
                    nullify = !cond_hit;
                    next_pc = cond_hit ? br_tgt : seq4;
                end
                default: next_pc = seq4;
            endcase
        end
    end

    // PC register: reset vector, hold on stall, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_VEC;
        end else if (!stall) begin
            pc <= next_pc;
        end
    end

    // R2: a stalled cycle leaves the PC untouched.
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && stall) |=> $stable(pc));

    // R2: an unstalled cycle moves the PC to the resolved address.
    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall) |=> (pc == $past(next_pc)));

    // R4: absolute jumps stay inside the current upper address region.
    assert_abs_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && pc_sel == 3'(PCS_ABS)) |-> (next_pc[XLEN-1 -: HI_W] == pc[XLEN-1 -: HI_W]));

    // R9: the slot is discarded only for a failing likely branch.
    assert_nullify_likely_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> (!irq && !taken && pc_sel == 3'(PCS_BRL) && next_pc == pc + XLEN'(4)));

    // R11: an interrupt always transfers and saves the current PC.
    assert_irq_override_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (taken && !nullify && link_we && link_idx == IDX_W'(EPC_IDX)
                 && link_val == pc && next_pc == rs_val));

    // R8: a non-taken, non-interrupt cycle never lands on a branch target
    // other than the sequential successors.
    assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && !irq) |-> (next_pc == pc + XLEN'(4) || next_pc == pc + XLEN'(8)));

endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for npc_unit: a driver task applies one decode cycle,
// computes the expected outputs from the requirements and queues them;
// a monitor pops and compares mid-cycle.
module npc_unit_bench;

    localparam real CLK_NS = 8.0;
    localparam logic [31:0] RVEC = 32'hBFC0_0000;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] npc;
        logic        tk;
        logic        nl;
        logic        lwe;
        logic [5:0]  lidx;
        logic [31:0] lval;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b1;
    logic [2:0]  pc_sel = 3'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic        link_en = 1'b0;
    logic        irq = 1'b0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [25:0] jfield = '0;
    logic [31:0] pc;
    logic [31:0] next_pc;
    logic        taken;
    logic        nullify;
    logic        link_we;
    logic [5:0]  link_idx;
    logic [31:0] link_val;

    exp_t        sb_q[$];
    logic [31:0] m_pc = RVEC;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .stall(stall), .pc_sel(pc_sel),
        .cond_sel(cond_sel), .link_en(link_en), .irq(irq),
        .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .jfield(jfield),
        .pc(pc), .next_pc(next_pc), .taken(taken), .nullify(nullify),
        .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
    );

    // Condition truth per R7.
    function automatic bit cond_true(input int c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) < 0;
            3: return $signed(a) <= 0;
            4: return $signed(a) >= 0;
            5: return $signed(a) > 0;
            6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // Monitor: compare one queued item per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "pc", pc, e.pc);
                check(e.tag, "next_pc", next_pc, e.npc);
                check(e.tag, "taken", 32'(taken), 32'(e.tk));
                check(e.tag, "nullify", 32'(nullify), 32'(e.nl));
                check(e.tag, "link_we", 32'(link_we), 32'(e.lwe));
                if (e.lwe) begin
                    check(e.tag, "link_idx", 32'(link_idx), 32'(e.lidx));
                    check(e.tag, "link_val", link_val, e.lval);
                end
            end
        end
    end

    // Driver: apply one cycle of inputs and queue what the requirements predict.
    task automatic drive(input int sel, input int cnd, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [25:0] jf, input bit lnk,
                         input bit iq, input bit st, input string tag);
        exp_t e;
        bit   hit;
        @(posedge clk);
        #1;
        pc_sel = 3'(sel); cond_sel = 3'(cnd); rs_val = a; rt_val = b;
        imm = im; jfield = jf; link_en = lnk; irq = iq; stall = st;
        hit = cond_true(cnd, a, b);
        e.tag = tag; e.pc = m_pc; e.npc = m_pc + 32'd4;
        e.tk = 1'b0; e.nl = 1'b0;
        e.lwe = lnk && (sel >= 2 && sel <= 5); e.lidx = 6'd31; e.lval = m_pc + 32'd8;
        if (iq) begin
            e.npc = a; e.tk = 1'b1; e.lwe = 1'b1; e.lidx = 6'd46; e.lval = m_pc;
        end else begin
            case (sel)
                1: e.npc = m_pc + 32'd8;
                2: begin e.npc = a; e.tk = 1'b1; end
                3: begin e.npc = {m_pc[31:28], jf, 2'b00}; e.tk = 1'b1; end
                4, 5: begin
                    e.tk = hit;
                    if (hit) e.npc = m_pc + {{14{im[15]}}, im, 2'b00};
                    if (sel == 5) e.nl = !hit;
                end
                default: e.npc = m_pc + 32'd4;
            endcase
        end
        sb_q.push_back(e);
        if (!st) m_pc = e.npc;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; stall = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_pc = RVEC;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1: reset vector visible after reset.
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R1_reset_vector");
        // R3 / R2: sequential steps and a stall.
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3_seq4");
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3_seq8");
        drive(7, 0, 0, 0, 0, 0, 0, 0, 0, "R3_code7_as_seq4");
        drive(1, 0, 0, 0, 0, 0, 0, 0, 1, "R2_stall_hold");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2_after_stall");
        // R5: register jump, condition code 7 ignored; R10 link on it.
        drive(2, 7, 32'hA000_1000, 0, 0, 0, 1, 0, 0, "R5_reg_jump_R10");
        // R4: absolute jump keeps upper PC bits.
        drive(3, 0, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 0, "R4_abs_jump");
        drive(2, 0, 32'h0000_1000, 0, 0, 0, 0, 0, 0, "R5_reg_jump_low");
        // R6 / R7: each condition, taken and not taken.
        drive(4, 0, 32'd5, 32'd5, 16'h0004, 0, 0, 0, 0, "R6_R7_eq_taken");
        drive(4, 0, 32'd5, 32'd6, 16'h0004, 0, 0, 0, 0, "R8_R7_eq_fall");
        drive(4, 1, 32'd5, 32'd6, 16'hFFFF, 0, 0, 0, 0, "R6_R7_ne_neg_off");
        drive(4, 2, 32'h8000_0000, 0, 16'h0010, 0, 0, 0, 0, "R7_ltz_minneg");
        drive(4, 2, 32'd0, 0, 16'h0010, 0, 0, 0, 0, "R7_ltz_zero_fall");
        drive(4, 3, 32'd0, 0, 16'h0002, 0, 0, 0, 0, "R7_lez_zero");
        drive(4, 3, 32'd1, 0, 16'h0002, 0, 0, 0, 0, "R7_lez_one_fall");
        drive(4, 4, 32'd0, 0, 16'h0003, 0, 0, 0, 0, "R7_gez_zero");
        drive(4, 4, 32'hFFFF_FFFF, 0, 16'h0003, 0, 0, 0, 0, "R7_gez_neg_fall");
        drive(4, 5, 32'd0, 0, 16'h0003, 0, 0, 0, 0, "R7_gtz_zero_fall");
        drive(4, 5, 32'd1, 0, 16'h8000, 0, 0, 0, 0, "R6_R7_gtz_minoff");
        drive(4, 6, 0, 0, 16'h7FFF, 0, 0, 0, 0, "R7_always");
        drive(4, 7, 0, 0, 16'h7FFF, 0, 0, 0, 0, "R7_never");
        // R9: likely branch fall-through and taken.
        drive(5, 0, 32'd1, 32'd2, 16'h0020, 0, 0, 0, 0, "R9_likely_fall");
        drive(5, 1, 32'd1, 32'd2, 16'h0020, 0, 0, 0, 0, "R9_R6_likely_taken");
        // R10: link written on a non-taken branch, not on sequential codes.
        drive(4, 0, 32'd1, 32'd2, 16'h0020, 0, 1, 0, 0, "R10_link_fall");
        drive(1, 0, 0, 0, 0, 0, 1, 0, 0, "R10_no_link_seq8");
        // R11: interrupt over a failing likely branch with link request.
        drive(5, 7, 32'h8000_0180, 0, 16'h0020, 0, 1, 1, 0, "R11_irq_override");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11_after_irq");
        // R1: reset during a stall still restores the vector.
        do_reset();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R1_reset_over_stall");
        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule